// File: doc/BRIEF.md
# Multi-Mode Serial Shift Register

An 8-bit serial shifter for a peripheral-interface chip. It moves a byte in from, or out onto, a serial data pin. A companion clock pin carries the shift pulses. Depending on the mode, that clock pin either drives pulses generated inside the block or receives pulses from an external device. A 3-bit mode input selects one of eight behaviours, which differ in three ways: the shift direction, the pulse source (an interval timer's divisor and timeout, the system clock, or the external pin), and what a modulo-8 pulse counter does once eight pulses have been seen.

The CPU sees one register through a read strobe and a write strobe. Either strobe clears the shift flag, restarts the pulse count and, in the internally clocked modes, launches a new transfer. A timer-paced transfer starts at once if the flag was set when the CPU accessed the register. Otherwise it waits for the timer's next timeout pulse.

Internal pulses come from a four-state machine:
- `PG_IDLE`: the clock pin is held high.
- `PG_ARM`: waiting for a timeout.
- `PG_LOW`: the low half of a pulse.
- `PG_HIGH`: the high half of a pulse.

Its transitions are:
- IDLE→LOW or IDLE→ARM on an access.
- ARM→LOW on a timeout.
- LOW→HIGH when the low half ends. That edge is also the shift edge.
- LOW→IDLE when the eighth shift of a one-shot mode ends.
- HIGH→LOW when the high half ends.
- Any state→IDLE when the mode is not internally clocked.
- Any state→LOW or ARM on a new access.

Top module: `ser_shift_unit`

## Requirements
- R1: Mode codes are 0 off, 1 in/timer, 2 in/sysclk, 3 in/external, 4 out/timer free-run, 5 out/timer, 6 out/sysclk, 7 out/external. `sclk_oe` is 1 exactly in modes 1, 2, 4, 5 and 6. `sdat_oe` is 1 exactly in modes 4 to 7. `sclk_out` is high whenever no pulse is in its low half.
- R2: A write loads `cpu_wdata`, and `cpu_rdata` shows the register one cycle later. Any read or write clears `shift_flag` and restarts the modulo-8 count.
- R3: In mode 0, `shift_flag` stays 0. The register still shifts in `sdat_in` on every rising edge of `sclk_in`.
- R4: When shifting in, the new bit enters bit 0 and older bits move toward bit 7. After eight shifts the register holds the eight bits, first-received in bit 7.
- R5: When shifting out, each shift drives the pre-shift bit 7 onto `sdat_out` and rotates the register left (bit 7 into bit 0). `sdat_out` changes only on a shift and keeps its last level afterwards.
- R6: In timer-paced modes (1, 4, 5), each half of a pulse on `sclk_out` lasts `tmr_div`+2 clock cycles, low half first. The shift takes place at the end of the low half.
- R7: A timer-paced transfer begins its first low half on the cycle after the access if `shift_flag` was 1 at the access. Otherwise it begins on the cycle after the next `tmr_tout` pulse, and `sclk_out` stays high until then. In modes 2 and 6 the start is always immediate, and each half lasts one cycle.
- R8: Modes 1, 2, 5 and 6 produce exactly eight pulses. `shift_flag` rises together with the eighth shift, after which `sclk_out` stays high.
- R9: Mode 4 keeps pulsing after eight shifts, so the loaded byte repeats on `sdat_out`. `shift_flag` is never set.
- R10: In modes 3 and 7, a rising edge on `sclk_in` causes one shift two clock edges later (one edge to sample, one to shift). Every eighth pulse sets `shift_flag`, and shifting continues past it.
- R11: After reset, the register is 0, `shift_flag` is 0, `sclk_out` is high and `sdat_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Operating mode code |
| cpu_rd | input | 1 | One-cycle CPU read strobe |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current register contents |
| tmr_div | input | 8 | Half-period divisor from the interval timer |
| tmr_tout | input | 1 | One-cycle timer timeout pulse |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock, idle high |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| sdat_in | input | 1 | Serial data in |
| sdat_out | output | 1 | Serial data out |
| sdat_oe | output | 1 | Drive enable for the serial data pin |
| shift_flag | output | 1 | Eight-pulse flag |

## Verification
The bench sweeps every byte through the system-clock modes and runs divisors 0, 1 and 3 through the timer modes. It predicts each pulse edge and each data bit from the half-period arithmetic.

It drives the start rule both ways, with the flag set and with it clear, to catch two faults:
- a design that ignores the prior flag, which starts early;
- a design that waits for a timeout it should not need, which stalls.

Free-run mode is run for sixteen pulses to expose a counter that stops it or raises the flag. External-clock runs go past eight pulses and then re-access the register mid-count, to catch three faults:
- a counter that halts shifting;
- a counter that keeps a stale count;
- a flag that leaks through in mode 0.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    typedef enum logic [2:0] {
        M_OFF      = 3'd0,
        M_IN_TMR   = 3'd1,
        M_IN_SYS   = 3'd2,
        M_IN_EXT   = 3'd3,
        M_OUT_FREE = 3'd4,
        M_OUT_TMR  = 3'd5,
        M_OUT_SYS  = 3'd6,
        M_OUT_EXT  = 3'd7
    } ssu_mode_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_ARM,
        PG_LOW,
        PG_HIGH
    } pg_state_e;

    function automatic logic is_timer(input ssu_mode_e m);
        return (m == M_IN_TMR) || (m == M_OUT_FREE) || (m == M_OUT_TMR);
    endfunction

    function automatic logic is_sys(input ssu_mode_e m);
        return (m == M_IN_SYS) || (m == M_OUT_SYS);
    endfunction

    function automatic logic is_internal(input ssu_mode_e m);
        return is_timer(m) || is_sys(m);
    endfunction

    function automatic logic is_oneshot(input ssu_mode_e m);
        return is_internal(m) && (m != M_OUT_FREE);
    endfunction

    function automatic logic is_counting(input ssu_mode_e m);
        return (m != M_OFF) && (m != M_OUT_FREE);
    endfunction

endpackage

// File: rtl/ssu_edge_sync.sv
module ssu_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= pin_i;
            prev_q <= samp_q;
        end
    end

    always_comb begin
        rise_o = samp_q & ~prev_q;
    end

    // R10: one external edge yields a single shift request
    a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ssu_pulse_gen.sv
module ssu_pulse_gen
    import ssu_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int HALF_EXTRA = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssu_mode_e        mode_i,
    input  logic             access_i,
    input  logic             flag_i,
    input  logic             last_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tout_i,
    output logic             shift_o,
    output logic             sclk_o
);

    localparam int HC_W = DIV_W + 2;

    pg_state_e       state_q, state_d;
    logic [HC_W-1:0] hcnt_q, hcnt_d;
    logic [HC_W-1:0] half_load;
    logic            internal;
    logic            oneshot;

    always_comb begin
        internal  = is_internal(mode_i);
        oneshot   = is_oneshot(mode_i);
        half_load = is_sys(mode_i) ? '0
                  : HC_W'(div_i) + HC_W'(HALF_EXTRA - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        shift_o = 1'b0;
        unique case (state_q)
            PG_IDLE: begin
                state_d = PG_IDLE;
            end
            PG_ARM: begin
                if (tout_i) begin
                    state_d = PG_LOW;
                    hcnt_d  = half_load;
                end
            end
            PG_LOW: begin
                if (hcnt_q == '0) begin
                    shift_o = 1'b1;
                    if (oneshot && last_i) begin
                        state_d = PG_IDLE;
                    end else begin
                        state_d = PG_HIGH;
                        hcnt_d  = half_load;
                    end
                end else begin
                    hcnt_d = hcnt_q - 1'b1;
                end
            end
            PG_HIGH: begin
                if (hcnt_q == '0) begin
                    state_d = PG_LOW;
                    hcnt_d  = half_load;
                end else begin
                    hcnt_d = hcnt_q - 1'b1;
                end
            end
        endcase
        if (access_i) begin
            shift_o = 1'b0;
            if (is_sys(mode_i) || flag_i) begin
                state_d = PG_LOW;
                hcnt_d  = half_load;
            end else begin
                state_d = PG_ARM;
            end
        end
        if (!internal) begin
            state_d = PG_IDLE;
            shift_o = 1'b0;
        end
    end

    always_comb begin
        sclk_o = (state_q != PG_LOW);
    end

    // R1: outside the internally clocked modes the clock output rests high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !internal |=> sclk_o);

    // R7: an armed transfer holds until a timeout arrives
    a_r7_arm_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ARM && !tout_i && !access_i && internal)
        |=> (state_q == PG_ARM && sclk_o));

endmodule

// File: rtl/ssu_shift_core.sv
module ssu_shift_core
    import ssu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssu_mode_e        mode_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             sdat_i,
    input  logic             int_shift_i,
    input  logic             ext_rise_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             sdat_o,
    output logic             flag_o,
    output logic             last_o
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] sreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             dout_q;
    logic             access;
    logic             shift_evt;
    logic             shift_eff;
    logic             out_dir;
    logic             counting;

    always_comb begin
        access    = wr_i | rd_i;
        out_dir   = mode_i[2];
        counting  = is_counting(mode_i);
        shift_evt = is_internal(mode_i) ? int_shift_i
                  : ((mode_i == M_OFF) || (mode_i == M_IN_EXT) || (mode_i == M_OUT_EXT))
                    ? ext_rise_i : 1'b0;
        shift_eff = shift_evt & ~access;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (wr_i) begin
            sreg_q <= wdata_i;
        end else if (shift_eff) begin
            if (out_dir) begin
                sreg_q <= {sreg_q[WIDTH-2:0], sreg_q[WIDTH-1]};
            end else begin
                sreg_q <= {sreg_q[WIDTH-2:0], sdat_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (shift_eff && out_dir) begin
            dout_q <= sreg_q[WIDTH-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (access) begin
            cnt_q <= '0;
        end else if (shift_eff && counting) begin
            cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (mode_i == M_OFF || access) begin
            flag_q <= 1'b0;
        end else if (shift_eff && counting && cnt_q == CNT_TOP) begin
            flag_q <= 1'b1;
        end
    end

    always_comb begin
        rdata_o = sreg_q;
        sdat_o  = dout_q;
        flag_o  = flag_q;
        last_o  = (cnt_q == CNT_TOP);
    end

    // R2: any CPU access leaves the flag clear on the next cycle
    a_r2_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !flag_q);

    // R3: mode 0 keeps the flag low
    a_r3_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_OFF) |=> !flag_q);

    // R9: free-run never raises a clear flag
    a_r9_free_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_OUT_FREE && !flag_q) |=> !flag_q);

    // R5: serial output moves only on an outbound shift
    a_r5_dout_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(shift_evt && out_dir));

endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
    import ssu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [WIDTH-1:0] cpu_wdata,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic [DIV_W-1:0] tmr_div,
    input  logic             tmr_tout,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    input  logic             sdat_in,
    output logic             sdat_out,
    output logic             sdat_oe,
    output logic             shift_flag
);

    ssu_mode_e mode;
    logic      ext_rise;
    logic      int_shift;
    logic      flag;
    logic      last;

    always_comb begin
        mode       = ssu_mode_e'(mode_sel);
        sclk_oe    = is_internal(mode);
        sdat_oe    = mode_sel[2];
        shift_flag = flag;
    end

    ssu_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sclk_in),
        .rise_o (ext_rise)
    );

    ssu_pulse_gen #(
        .DIV_W      (DIV_W),
        .HALF_EXTRA (2)
    ) u_pgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .access_i (cpu_rd | cpu_wr),
        .flag_i   (flag),
        .last_i   (last),
        .div_i    (tmr_div),
        .tout_i   (tmr_tout),
        .shift_o  (int_shift),
        .sclk_o   (sclk_out)
    );

    ssu_shift_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .wr_i        (cpu_wr),
        .rd_i        (cpu_rd),
        .wdata_i     (cpu_wdata),
        .sdat_i      (sdat_in),
        .int_shift_i (int_shift),
        .ext_rise_i  (ext_rise),
        .rdata_o     (cpu_rdata),
        .sdat_o      (sdat_out),
        .flag_o      (flag),
        .last_o      (last)
    );

endmodule

// File: tb/ser_shift_unit_tb_top.sv
module ser_shift_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] tmr_div = 8'h00;
    logic       tmr_tout = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sclk_out;
    logic       sclk_oe;
    logic       sdat_in = 1'b0;
    logic       sdat_out;
    logic       sdat_oe;
    logic       shift_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ser_shift_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .tmr_div    (tmr_div),
        .tmr_tout   (tmr_tout),
        .sclk_in    (sclk_in),
        .sclk_out   (sclk_out),
        .sclk_oe    (sclk_oe),
        .sdat_in    (sdat_in),
        .sdat_out   (sdat_out),
        .sdat_oe    (sdat_oe),
        .shift_flag (shift_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input bit is_wr, input logic [7:0] v);
        cpu_wr    = is_wr;
        cpu_rd    = !is_wr;
        cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_rd = 1'b0;
    endtask

    task automatic clear_flag();
        mode_sel = 3'd3;
        @(negedge clk);
        access(1'b0, 8'h00);
        @(negedge clk);
        chk("R2 flag cleared by read", shift_flag, 0);
    endtask

    task automatic ext_pulse(input bit b);
        sdat_in = b;
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_int(input logic [2:0] m, input int ndiv,
                           input logic [7:0] v, input logic [7:0] in_b,
                           input bit imm);
        int  h;
        int  p;
        bit  outm;
        bit  ones;
        h    = (m == 3'd2 || m == 3'd6) ? 1 : ndiv + 2;
        p    = (m == 3'd4) ? 16 : 8;
        outm = m[2];
        ones = (m != 3'd4);
        mode_sel = m;
        tmr_div  = ndiv[7:0];
        @(negedge clk);
        access(1'b1, v);
        if (!imm && h != 1) begin
            for (int w = 0; w < 3; w++) begin
                chk("R7 clock held until timeout", sclk_out, 1);
                @(negedge clk);
            end
            tmr_tout = 1'b1;
            @(negedge clk);
            tmr_tout = 1'b0;
        end
        for (int n = 0; n < 2 * h * p; n++) begin
            chk("R6 R8 clock waveform", sclk_out, ((n % (2 * h)) < h) ? 0 : 1);
            chk("R8 R9 flag timing", shift_flag, (ones && n >= 15 * h) ? 1 : 0);
            if (outm && (n % (2 * h)) == h)
                chk("R5 serial out bit", sdat_out, v[7 - ((n / (2 * h)) % 8)]);
            if (!outm && (n % (2 * h)) == 0)
                sdat_in = in_b[7 - (n / (2 * h))];
            @(negedge clk);
        end
        chk("R4 R5 register after transfer", cpu_rdata, outm ? v : in_b);
        if (ones) begin
            for (int w = 0; w < 4; w++) begin
                chk("R8 pulses stopped", sclk_out, 1);
                if (outm) chk("R5 last level held", sdat_out, v[0]);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset register", cpu_rdata, 0);
        chk("R11 reset flag", shift_flag, 0);
        chk("R11 reset clock high", sclk_out, 1);
        chk("R11 reset data out", sdat_out, 0);

        for (int m = 0; m < 8; m++) begin
            mode_sel = m[2:0];
            @(negedge clk);
            chk("R1 clock enable", sclk_oe,
                (m == 1 || m == 2 || m == 4 || m == 5 || m == 6) ? 1 : 0);
            chk("R1 data enable", sdat_oe, (m >= 4) ? 1 : 0);
            chk("R1 clock idle", sclk_out, 1);
        end

        // mode 0: write readback, shifting in, flag held low
        mode_sel = 3'd0;
        @(negedge clk);
        access(1'b1, 8'h3A);
        chk("R2 write readback", cpu_rdata, 8'h3A);
        for (int k = 0; k < 8; k++) ext_pulse(8'hF0 >> (7 - k));
        chk("R3 mode0 shifts in", cpu_rdata, 8'hF0);
        chk("R3 mode0 flag low", shift_flag, 0);

        // mode 3: external shift in, flag at eight, continues
        mode_sel = 3'd3;
        @(negedge clk);
        access(1'b1, 8'h00);
        for (int k = 0; k < 7; k++) ext_pulse(8'h5A >> (7 - k));
        chk("R10 no flag after seven", shift_flag, 0);
        ext_pulse(1'b0);
        chk("R10 flag after eight", shift_flag, 1);
        chk("R4 external byte", cpu_rdata, 8'h5A);
        ext_pulse(1'b1);
        ext_pulse(1'b0);
        ext_pulse(1'b1);
        chk("R10 shifting continues", cpu_rdata, 8'hD5);
        chk("R10 flag stays", shift_flag, 1);
        access(1'b0, 8'h00);
        chk("R2 read clears flag", shift_flag, 0);
        for (int k = 0; k < 5; k++) ext_pulse(1'b0);
        chk("R2 count restarted", shift_flag, 0);
        for (int k = 0; k < 3; k++) ext_pulse(1'b0);
        chk("R10 flag after fresh eight", shift_flag, 1);

        // mode 7: external shift out
        mode_sel = 3'd7;
        @(negedge clk);
        access(1'b1, 8'hE1);
        for (int k = 0; k < 8; k++) begin
            ext_pulse(1'b0);
            chk("R5 external out bit", sdat_out, (8'hE1 >> (7 - k)) & 1);
            chk("R10 out flag", shift_flag, (k == 7) ? 1 : 0);
        end
        ext_pulse(1'b0);
        chk("R10 out continues", sdat_out, 1);
        chk("R5 rotated register", cpu_rdata, 8'hC3);

        // timer-paced modes across divisors
        for (int d = 0; d < 3; d++) begin
            int nd;
            nd = (d == 2) ? 3 : d;
            clear_flag();
            run_int(3'd5, nd, 8'hA5, 8'h00, 1'b0);
            run_int(3'd5, nd, 8'h3C, 8'h00, 1'b1);
            run_int(3'd1, nd, 8'h00, 8'hB2, 1'b1);
            clear_flag();
            run_int(3'd1, nd, 8'hFF, 8'h4D, 1'b0);
        end

        // free-running output
        clear_flag();
        run_int(3'd4, 1, 8'h81, 8'h00, 1'b0);
        chk("R9 free run still pulsing", sclk_out, 0);
        chk("R9 no flag", shift_flag, 0);

        // system-clock sweeps over all bytes
        for (int v = 0; v < 256; v++) begin
            run_int(3'd6, 0, v[7:0], 8'h00, 1'b1);
            run_int(3'd2, 0, v[7:0], ~v[7:0], 1'b1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule